// File: doc/BRIEF.md
# Paged Host Register Window

This block sits between a byte-wide host I/O bus and the converter channels of a larger chip. It claims a 32-byte window whose base is set by switch inputs on address bits 9 to 5. A page register at the fixed offset 1Eh picks one of four register pages. Every access to offsets other than 1Eh is decoded against the selected page.

The 16-bit quantities cross the byte bus without tearing. Commanded angles are written high byte first, and each channel loads its whole 16-bit value only when its low byte arrives. Measured angles are read high byte first. Reading the high byte freezes the matching low byte until that low byte is read.

Page 1 carries three handshakes: a keyed save/restore command register that clears itself when the storage side reports completion, a watchdog code register that the block replaces with its bitwise inverse after a fixed delay, and a level-held soft reset.

Top module: `hostRegWindow`

## Requirements
- R1: An access hits the window only when hostAddr[9:5] equals baseSel. A miss writes nothing and reads 00h.
- R2: A write to offset 1Eh on any page loads the page number from data bits [1:0]. A read of 1Eh returns the page number in bits [1:0] with the upper bits zero.
- R3: On page 0, offset 2k+1 stages the high byte of channel k and offset 2k holds its low byte. The channel's angleOut slice changes only on the low-byte write, one cycle later, to {staged high, written low}. Each channel has its own staging byte.
- R4: On page 2, offset 2k+1 reads wrapIn[k] bits 15:8 and captures its bits 7:0. A later read of offset 2k returns the captured byte and releases it. With no capture held for channel k, offset 2k reads the live low byte.
- R5: On page 1, offset 11h stages the high byte of the save register and offset 10h commits the 16-bit command. 5555h raises saveReq for one cycle and AAAAh raises restoreReq for one cycle. While the operation runs, the register reads back the command. After saveDone, the register reads 0000h. Other values are ignored and the register stays 0000h.
- R6: A command written while an operation is running raises no request and leaves the register value unchanged.
- R7: On page 1, offset 01h stages the watchdog high byte and offset 00h commits the code. The code reads back at once. Exactly WDOG_DELAY clock edges after the commit edge, the code reads as its bitwise inverse, and it stays so until the next commit.
- R8: On page 1, a write to offset 04h sets softReset to data bit 0 and holds it there until the next write. The same offset reads the level back in bit 0.
- R9: Reads return 00h at unmapped offsets, at the write-only angle offsets on page 0, and at every offset of page 3 except 1Eh. Writes to the read-only page 2 offsets change nothing.
- R10: After reset, the page is 0, every angle is 0000h, the save register is 0000h with no request raised, the watchdog code is 0000h, and softReset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseSel | input | ADDR_W-5 | Window base, compared with hostAddr[9:5] |
| hostAddr | input | ADDR_W | Host byte address |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, valid in the cycle of hostRd |
| wrapIn | input | 16*NUM_CH | Measured angle of each channel, channel k at bits 16k+15:16k |
| angleOut | output | 16*NUM_CH | Commanded angle of each channel, channel k at bits 16k+15:16k |
| saveReq | output | 1 | One-cycle pulse requesting a save of the setup |
| restoreReq | output | 1 | One-cycle pulse requesting a restore of defaults |
| saveDone | input | 1 | Storage side reports that the running operation has finished |
| softReset | output | 1 | Level-held soft reset |

## Verification
The angle path is exercised with interleaved high-byte writes to two channels before either low byte is written. This shows whether staging is per channel or shared, and whether the output moves early on a high byte. The measured-angle path changes wrapIn between the high read and the low read, which separates a frozen low byte from a live one. It also reads a different channel's low byte after a high read, which shows whether the freeze is tied to the channel. The save register is given both keys, a non-key value, and a key written while an operation runs. The watchdog is sampled one edge before and exactly at the programmed delay.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  localparam int WIN_W  = 5;
  localparam int CHAN_W = 3;

  localparam logic [WIN_W-1:0] PAGE_OFS    = 5'h1E;
  localparam logic [WIN_W-1:0] SAVE_LO_OFS = 5'h10;
  localparam logic [WIN_W-1:0] SAVE_HI_OFS = 5'h11;
  localparam logic [WIN_W-1:0] WDOG_LO_OFS = 5'h00;
  localparam logic [WIN_W-1:0] WDOG_HI_OFS = 5'h01;
  localparam logic [WIN_W-1:0] SRST_OFS    = 5'h04;

  localparam logic [1:0] PG_ANGLE = 2'd0;
  localparam logic [1:0] PG_CTRL  = 2'd1;
  localparam logic [1:0] PG_MIRR  = 2'd2;

  localparam logic [15:0] SAVE_KEY    = 16'h5555;
  localparam logic [15:0] RESTORE_KEY = 16'hAAAA;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PAGE, SEL_SAVE_LO, SEL_SAVE_HI, SEL_WDOG_LO,
    SEL_WDOG_HI, SEL_SRST, SEL_MIR_LO, SEL_MIR_HI
  } rdSel_e;

  typedef struct packed {
    logic              angleHiWr;
    logic              angleLoWr;
    logic              saveHiWr;
    logic              saveLoWr;
    logic              wdogHiWr;
    logic              wdogLoWr;
    logic              srstWr;
    logic              mirHiRd;
    logic              mirLoRd;
    logic [CHAN_W-1:0] chan;
    rdSel_e            rdSel;
  } regStrobe_t;

endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-WIN_W-1:0] baseSel,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostWr,
  input  logic                    hostRd,
  input  logic [1:0]              pageData,
  output regStrobe_t              strb,
  output logic [1:0]              page
);

  localparam logic [WIN_W-1:0] CH_SPAN = WIN_W'(2 * NUM_CH);

  logic [WIN_W-1:0] offs;
  logic             hit;
  logic             pageWr;

  assign offs = hostAddr[WIN_W-1:0];
  assign hit  = (hostAddr[ADDR_W-1:WIN_W] == baseSel);

  always_comb begin
    strb   = '0;
    strb.rdSel = SEL_NONE;
    pageWr = 1'b0;
    if (hit) begin
      if (offs == PAGE_OFS) begin
        pageWr = hostWr;
        if (hostRd) strb.rdSel = SEL_PAGE;
      end else begin
        case (page)
          PG_ANGLE: begin
            if (offs < CH_SPAN) begin
              strb.chan      = offs[CHAN_W:1];
              strb.angleHiWr = hostWr & offs[0];
              strb.angleLoWr = hostWr & ~offs[0];
            end
          end
          PG_CTRL: begin
            if (offs == SAVE_LO_OFS) begin
              strb.saveLoWr = hostWr;
              if (hostRd) strb.rdSel = SEL_SAVE_LO;
            end else if (offs == SAVE_HI_OFS) begin
              strb.saveHiWr = hostWr;
              if (hostRd) strb.rdSel = SEL_SAVE_HI;
            end else if (offs == WDOG_LO_OFS) begin
              strb.wdogLoWr = hostWr;
              if (hostRd) strb.rdSel = SEL_WDOG_LO;
            end else if (offs == WDOG_HI_OFS) begin
              strb.wdogHiWr = hostWr;
              if (hostRd) strb.rdSel = SEL_WDOG_HI;
            end else if (offs == SRST_OFS) begin
              strb.srstWr = hostWr;
              if (hostRd) strb.rdSel = SEL_SRST;
            end
          end
          PG_MIRR: begin
            if (offs < CH_SPAN) begin
              strb.chan    = offs[CHAN_W:1];
              strb.mirHiRd = hostRd & offs[0];
              strb.mirLoRd = hostRd & ~offs[0];
              if (hostRd) strb.rdSel = offs[0] ? SEL_MIR_HI : SEL_MIR_LO;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       page <= PG_ANGLE;
    else if (pageWr) page <= pageData;
  end

  // R2: the page follows a write at offset 1Eh
  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    pageWr |=> (page == $past(pageData)));

  // R1: an access outside the window never moves the page
  assert_miss_page_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr[ADDR_W-1:WIN_W] != baseSel) |=> $stable(page));

  // R1: an access outside the window raises no strobe
  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr[ADDR_W-1:WIN_W] != baseSel) |->
      !(strb.angleLoWr || strb.saveLoWr || strb.wdogLoWr || strb.srstWr || strb.mirHiRd));

endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostRegPkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int WDOG_DELAY = 25000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [7:0]            wrData,
  input  logic [1:0]            page,
  input  logic [16*NUM_CH-1:0]  wrapIn,
  input  logic                  saveDone,
  output logic [7:0]            rdData,
  output logic [16*NUM_CH-1:0]  angleOut,
  output logic                  saveReq,
  output logic                  restoreReq,
  output logic                  softReset
);

  localparam int WD_CNT_W = $clog2(WDOG_DELAY + 1);

  logic [15:0]        wrapArr [NUM_CH];

  logic [7:0]         saveStage;
  logic [15:0]        saveReg;
  logic               saveBusy;
  logic [15:0]        saveCmd;

  logic [7:0]         wdogStage;
  logic [15:0]        wdogCode;
  logic [WD_CNT_W-1:0] wdogCnt;
  logic               wdogPend;

  logic [7:0]         holdLo;
  logic [CHAN_W-1:0]  holdCh;
  logic               holdValid;
  logic               holdHit;

  // ---------------- per-channel angle staging ----------------
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic [7:0]  hiStage;
    logic [15:0] angleReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiStage  <= '0;
        angleReg <= '0;
      end else if (strb.chan == CHAN_W'(k)) begin
        if (strb.angleHiWr) hiStage  <= wrData;
        if (strb.angleLoWr) angleReg <= {hiStage, wrData};
      end
    end
    assign angleOut[16*k +: 16] = angleReg;
    assign wrapArr[k]           = wrapIn[16*k +: 16];
  end

  // ---------------- save / restore command ----------------
  assign saveBusy = (saveReg != 16'h0000);
  assign saveCmd  = {saveStage, wrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveStage  <= '0;
      saveReg    <= '0;
      saveReq    <= 1'b0;
      restoreReq <= 1'b0;
    end else begin
      saveReq    <= 1'b0;
      restoreReq <= 1'b0;
      if (strb.saveHiWr) saveStage <= wrData;
      if (saveBusy) begin
        if (saveDone) saveReg <= 16'h0000;
      end else if (strb.saveLoWr) begin
        if (saveCmd == SAVE_KEY) begin
          saveReg <= saveCmd;
          saveReq <= 1'b1;
        end else if (saveCmd == RESTORE_KEY) begin
          saveReg    <= saveCmd;
          restoreReq <= 1'b1;
        end
      end
    end
  end

  // ---------------- watchdog inversion ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogStage <= '0;
      wdogCode  <= '0;
      wdogCnt   <= '0;
      wdogPend  <= 1'b0;
    end else begin
      if (strb.wdogHiWr) wdogStage <= wrData;
      if (strb.wdogLoWr) begin
        wdogCode <= {wdogStage, wrData};
        wdogCnt  <= WD_CNT_W'(WDOG_DELAY);
        wdogPend <= 1'b1;
      end else if (wdogPend) begin
        if (wdogCnt == WD_CNT_W'(1)) begin
          wdogCode <= ~wdogCode;
          wdogPend <= 1'b0;
        end else begin
          wdogCnt <= wdogCnt - WD_CNT_W'(1);
        end
      end
    end
  end

  // ---------------- soft reset level ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            softReset <= 1'b0;
    else if (strb.srstWr) softReset <= wrData[0];
  end

  // ---------------- measured angle read freeze ----------------
  assign holdHit = holdValid && (holdCh == strb.chan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLo    <= '0;
      holdCh    <= '0;
      holdValid <= 1'b0;
    end else if (strb.mirHiRd) begin
      holdLo    <= wrapArr[strb.chan][7:0];
      holdCh    <= strb.chan;
      holdValid <= 1'b1;
    end else if (strb.mirLoRd && holdHit) begin
      holdValid <= 1'b0;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    case (strb.rdSel)
      SEL_PAGE:    rdData = {6'b0, page};
      SEL_SAVE_LO: rdData = saveReg[7:0];
      SEL_SAVE_HI: rdData = saveReg[15:8];
      SEL_WDOG_LO: rdData = wdogCode[7:0];
      SEL_WDOG_HI: rdData = wdogCode[15:8];
      SEL_SRST:    rdData = {7'b0, softReset};
      SEL_MIR_HI:  rdData = wrapArr[strb.chan][15:8];
      SEL_MIR_LO:  rdData = holdHit ? holdLo : wrapArr[strb.chan][7:0];
      default:     rdData = 8'h00;
    endcase
  end

  // R3: angles move only on a low-byte write
  assert_angle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.angleLoWr |=> $stable(angleOut));

  // R5: completion clears the command register
  assert_save_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (saveDone && saveBusy) |=> (saveReg == 16'h0000));

  // R5: the two requests never coincide
  assert_req_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(saveReq && restoreReq));

  // R6: no request while an operation runs
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    (saveBusy && !saveDone) |=> !(saveReq || restoreReq) && $stable(saveReg));

  // R7: the code inverts when the delay expires
  assert_wdog_invert_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wdogPend && (wdogCnt == WD_CNT_W'(1)) && !strb.wdogLoWr) |=>
      (wdogCode == ~$past(wdogCode)));

  // R8: the reset level holds between writes
  assert_srst_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.srstWr |=> $stable(softReset));

endmodule

// File: rtl/hostRegWindow.sv
module hostRegWindow
  import hostRegPkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int NUM_CH     = 8,
  parameter int WDOG_DELAY = 25000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-WIN_W-1:0] baseSel,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostWr,
  input  logic                    hostRd,
  input  logic [7:0]              hostWrData,
  output logic [7:0]              hostRdData,
  input  logic [16*NUM_CH-1:0]    wrapIn,
  output logic [16*NUM_CH-1:0]    angleOut,
  output logic                    saveReq,
  output logic                    restoreReq,
  input  logic                    saveDone,
  output logic                    softReset
);

  regStrobe_t strb;
  logic [1:0] page;

  hostRegCtrl #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseSel  (baseSel),
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .pageData (hostWrData[1:0]),
    .strb     (strb),
    .page     (page)
  );

  hostRegData #(
    .NUM_CH     (NUM_CH),
    .WDOG_DELAY (WDOG_DELAY)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (hostWrData),
    .page       (page),
    .wrapIn     (wrapIn),
    .saveDone   (saveDone),
    .rdData     (hostRdData),
    .angleOut   (angleOut),
    .saveReq    (saveReq),
    .restoreReq (restoreReq),
    .softReset  (softReset)
  );

endmodule

// File: tb/hostRegWindow_tb.sv
module hostRegWindow_tb;

  localparam int ADDR_W = 10;
  localparam int NUM_CH = 8;
  localparam int DELAY  = 25000;
  localparam logic [4:0] BASE = 5'b10110;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [4:0]             baseSel = BASE;
  logic [ADDR_W-1:0]      hostAddr = '0;
  logic                   hostWr = 1'b0;
  logic                   hostRd = 1'b0;
  logic [7:0]             hostWrData = '0;
  logic [7:0]             hostRdData;
  logic [16*NUM_CH-1:0]   wrapIn = '0;
  logic [16*NUM_CH-1:0]   angleOut;
  logic                   saveReq, restoreReq, softReset;
  logic                   saveDone = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hostRegWindow #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .WDOG_DELAY(DELAY)) u_dut (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostRd(hostRd), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .wrapIn(wrapIn), .angleOut(angleOut),
    .saveReq(saveReq), .restoreReq(restoreReq), .saveDone(saveDone),
    .softReset(softReset));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wrAt(input logic [4:0] base, input logic [4:0] offs, input logic [7:0] d);
    hostAddr = {base, offs}; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic wr(input logic [4:0] offs, input logic [7:0] d);
    wrAt(BASE, offs, d);
  endtask

  task automatic rdAt(input logic [4:0] base, input logic [4:0] offs, output logic [7:0] d);
    hostAddr = {base, offs}; hostRd = 1'b1;
    #1 d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic rd(input logic [4:0] offs, output logic [7:0] d);
    rdAt(BASE, offs, d);
  endtask

  function automatic int ang(input int k);
    return int'(angleOut[16*k +: 16]);
  endfunction

  task automatic testReset();
    logic [7:0] d;
    rd(5'h1E, d);            chk("R10 page", d, 0);
    chk("R10 angles", int'(angleOut == '0), 1);
    chk("R10 requests", {saveReq, restoreReq}, 0);
    chk("R10 softReset", softReset, 0);
    wr(5'h1E, 8'd1);
    rd(5'h10, d);            chk("R10 save reg", d, 0);
    rd(5'h00, d);            chk("R10 wdog code", d, 0);
    wr(5'h1E, 8'd0);
  endtask

  task automatic testDecode();
    logic [7:0] d;
    wrAt(5'b00001, 5'h01, 8'h9A);
    wrAt(5'b00001, 5'h00, 8'hBC);
    chk("R1 miss write angle", ang(0), 0);
    wrAt(5'b10111, 5'h1E, 8'd2);
    rd(5'h1E, d);            chk("R1 miss write page", d, 0);
    rdAt(5'b00110, 5'h1E, d); chk("R1 miss read", d, 0);
  endtask

  task automatic testPage();
    logic [7:0] d;
    wr(5'h1E, 8'd3);
    rd(5'h1E, d);            chk("R2 page 3", d, 3);
    wr(5'h1E, 8'hFE);
    rd(5'h1E, d);            chk("R2 page bits", d, 2);
    wr(5'h1E, 8'd0);
  endtask

  task automatic testAngle();
    wr(5'h05, 8'h12);        // ch2 high
    chk("R3 no update on high", ang(2), 0);
    wr(5'h07, 8'h56);        // ch3 high
    wr(5'h04, 8'h34);        // ch2 low
    chk("R3 ch2 atomic", ang(2), 16'h1234);
    chk("R3 ch3 untouched", ang(3), 0);
    wr(5'h06, 8'h78);
    chk("R3 ch3 own stage", ang(3), 16'h5678);
  endtask

  task automatic testMirror();
    logic [7:0] d;
    wr(5'h1E, 8'd2);
    wrapIn[16*1 +: 16] = 16'hABCD;
    rd(5'h03, d);            chk("R4 high live", d, 8'hAB);
    wrapIn[16*1 +: 16] = 16'h1122;
    rd(5'h02, d);            chk("R4 low frozen", d, 8'hCD);
    rd(5'h02, d);            chk("R4 low released", d, 8'h22);
    wrapIn[16*0 +: 16] = 16'h3344;
    rd(5'h03, d);            chk("R4 high ch1", d, 8'h11);
    rd(5'h00, d);            chk("R4 other channel live", d, 8'h44);
    wrapIn[16*1 +: 16] = 16'h5566;
    rd(5'h02, d);            chk("R4 hold tied to channel", d, 8'h22);
  endtask

  task automatic testSave();
    logic [7:0] d;
    wr(5'h1E, 8'd1);
    wr(5'h11, 8'h55);
    wr(5'h10, 8'h55);
    chk("R5 save pulse", {saveReq, restoreReq}, 2'b10);
    @(negedge clk);
    chk("R5 pulse one cycle", saveReq, 0);
    rd(5'h10, d);            chk("R5 busy lo", d, 8'h55);
    rd(5'h11, d);            chk("R5 busy hi", d, 8'h55);
    wr(5'h11, 8'hAA);
    wr(5'h10, 8'hAA);
    chk("R6 no request when busy", {saveReq, restoreReq}, 0);
    rd(5'h11, d);            chk("R6 value kept", d, 8'h55);
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    rd(5'h10, d);            chk("R5 cleared lo", d, 0);
    rd(5'h11, d);            chk("R5 cleared hi", d, 0);
    wr(5'h11, 8'hAA);
    wr(5'h10, 8'hAA);
    chk("R5 restore pulse", {saveReq, restoreReq}, 2'b01);
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    wr(5'h11, 8'h12);
    wr(5'h10, 8'h34);
    chk("R5 non-key no pulse", {saveReq, restoreReq}, 0);
    rd(5'h11, d);            chk("R5 non-key ignored", d, 0);
  endtask

  task automatic testWdog();
    logic [7:0] d;
    wr(5'h01, 8'hC3);
    wr(5'h00, 8'h5A);
    rd(5'h00, d);            chk("R7 code at once", d, 8'h5A);
    repeat (DELAY - 2) @(negedge clk);
    rd(5'h00, d);            chk("R7 before delay", d, 8'h5A);
    rd(5'h00, d);            chk("R7 inverted at delay", d, 8'hA5);
    repeat (20) @(negedge clk);
    rd(5'h01, d);            chk("R7 inverse stays", d, 8'h3C);
  endtask

  task automatic testSrst();
    logic [7:0] d;
    wr(5'h04, 8'h01);
    chk("R8 asserted", softReset, 1);
    repeat (5) @(negedge clk);
    rd(5'h04, d);            chk("R8 held", {softReset, d}, 9'h101);
    wr(5'h04, 8'h00);
    chk("R8 released", softReset, 0);
  endtask

  task automatic testUnmapped();
    logic [7:0] d;
    rd(5'h07, d);            chk("R9 page1 unmapped", d, 0);
    wr(5'h1E, 8'd3);
    rd(5'h05, d);            chk("R9 page3", d, 0);
    wr(5'h1E, 8'd0);
    rd(5'h04, d);            chk("R9 write-only angle", d, 0);
    wr(5'h1E, 8'd2);
    wr(5'h05, 8'hEE);
    wr(5'h04, 8'hFF);
    chk("R9 read-only write ch2", ang(2), 16'h1234);
    wr(5'h1E, 8'd0);
    wr(5'h04, 8'h00);
    chk("R9 no staged byte leaked", ang(2), 16'h1200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDecode();
    testPage();
    testAngle();
    testMirror();
    testSave();
    testWdog();
    testSrst();
    testUnmapped();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule